// File: doc/BRIEF.md
# Serial Port with Atomic Register Aliases

This block is an asynchronous serial transmitter and receiver that sits on a simple word-addressed register bus. Software programs a bit-rate divisor and turns on a global enable. It then turns on the transmit and receive paths by writing ones to an atomic set address, pushes bytes into a transmit FIFO and pops received bytes from a receive FIFO. Every frame has eight data bits, no parity and one stop bit, and is sent least significant bit first.

The mode register and the status register each have two alias addresses, one that sets bits and one that clears them. Software can therefore change one control bit without a read-modify-write sequence. The receiver oversamples the line at sixteen ticks per bit and rejects start glitches and frames with a bad stop bit. A full receive FIFO latches a sticky overrun flag, and while that flag is set the receiver stores nothing more. The transmitter can send a break lasting one frame time.

Top module: `sp_uart`

## Requirements
- R1: After reset, mode (0x00) reads 0, status (0x10) reads 0x0100, divisor (0x40) reads 0 and `txd` is high.
- R2: For the mode and status registers, writing to base+0x4 clears and writing to base+0x8 sets only the bits written as one. Reading either alias returns the base register. A plain write to status leaves the overrun bit unchanged.
- R3: Mode bit 15 is the global enable. While it is 0, `txd` stays high, both FIFOs are empty and both serial engines are held in their idle state.
- R4: One bit time lasts 16 × (divisor + 1) clock cycles.
- R5: A transmitted frame is a low start bit, then 8 data bits LSB first, then a high stop bit. A new frame starts only while status bit 10 (transmit enable) is 1. Status bit 8 is 1 when the transmit FIFO is empty and the shifter is idle.
- R6: The transmit FIFO holds 4 bytes. Status bit 9 is 1 when it is full, and a write to 0x20 while it is full is dropped.
- R7: A read of 0x30 returns the oldest received byte in bits 7:0 and removes it from the FIFO. Status bit 0 is 1 while the receive FIFO holds data.
- R8: If a byte completes while the receive FIFO is full, status bit 1 (overrun) becomes 1. It stays 1 until a one is written to bit 1 at 0x14, and while it is 1 no received byte is stored.
- R9: A start edge whose line is high again at tick 8 of the start bit is discarded.
- R10: A frame whose stop bit samples low is discarded. The receiver then waits for the line to return high before it looks for a new start.
- R11: Writing a one to status bit 11 makes `txd` go low for 10 bit times, starting after any frame in progress has finished. Bit 11 then reads back as 0.
- R12: While status bit 12 (receive enable) is 0, incoming frames are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; pops the receive FIFO when the address is 0x30 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The bench checks that a clear through an alias removes only the bit written. A design that decoded the alias as a plain write would also wipe the neighbouring enables. It overfills both FIFOs. A receiver that kept storing after overrun would return a late byte where the bench expects none, and a transmitter that accepted a fifth byte would send an extra frame. It sends a short low glitch and a frame with a low stop bit. A receiver without the mid-bit recheck, or one that resynchronised during a held-low stop bit, would store a spurious byte. It measures the start-bit width under a non-zero divisor and the break width to the exact cycle, and it queues a break behind a frame in flight. A break that cut into that frame would corrupt its data bits.

// File: rtl/sp_pkg.sv
// Package: register addresses, status bit positions and engine state types
// shared by the serial port modules and its checker.
package sp_pkg;
    localparam logic [7:0] A_MODE   = 8'h00;
    localparam logic [7:0] A_STAT   = 8'h10;
    localparam logic [7:0] A_TXDATA = 8'h20;
    localparam logic [7:0] A_RXDATA = 8'h30;
    localparam logic [7:0] A_DIV    = 8'h40;
    localparam logic [7:0] OFS_CLR  = 8'h04;
    localparam logic [7:0] OFS_SET  = 8'h08;

    localparam int B_GLOBAL = 15;
    localparam int B_RXEN   = 12;
    localparam int B_BRK    = 11;
    localparam int B_TXEN   = 10;
    localparam int B_TXFULL = 9;
    localparam int B_TXIDLE = 8;
    localparam int B_OVR    = 1;
    localparam int B_RXAV   = 0;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_BREAK} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI} rx_state_e;
endpackage

// File: rtl/sp_fifo.sv
// Module: sp_fifo
// Small synchronous FIFO. The output shows the head word without a read latency.
// Assumes callers do not push when full or pop when empty; such requests are ignored.
// Flush empties the FIFO in one cycle.
module sp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == LW'(DEPTH));
    assign level   = cnt;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            if (do_push && !do_pop)      cnt <= cnt + LW'(1);
            else if (do_pop && !do_push) cnt <= cnt - LW'(1);
        end
    end
endmodule

// File: rtl/sp_tx.sv
// Module: sp_tx
// Frame transmitter: start bit, 8 data bits LSB first, stop bit, with 16 ticks per bit.
// It can also send a low break lasting 10 bit times. Bits start only on a tick,
// so every bit is exactly 16 ticks long. Assumes 'run' low means hold in idle.
module sp_tx
    import sp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       tx_en,
    input  logic       brk_req,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       fifo_pop,
    output logic       brk_done,
    output logic       busy,
    output logic       txd
);
    tx_state_e  st;
    logic [3:0] sub;
    logic [3:0] bitn;
    logic [7:0] sh;
    logic       txd_q;

    assign txd      = txd_q;
    assign busy     = (st != TX_IDLE);
    assign fifo_pop = run && tick && (st == TX_IDLE) && !brk_req && tx_en && !fifo_empty;
    assign brk_done = run && tick && (st == TX_BREAK) && (sub == 4'd15) && (bitn == 4'd9);

    // Frame sequencing; the line level is registered together with the state.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            st    <= TX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            sh    <= '0;
            txd_q <= 1'b1;
        end else if (tick) begin
            case (st)
                TX_IDLE: begin
                    sub  <= '0;
                    bitn <= '0;
                    if (brk_req) begin
                        st    <= TX_BREAK;
                        txd_q <= 1'b0;
                    end else if (fifo_pop) begin
                        st    <= TX_START;
                        txd_q <= 1'b0;
                        sh    <= fifo_data;
                    end
                end
                TX_START: begin
                    sub <= sub + 4'd1;
                    if (sub == 4'd15) begin
                        st    <= TX_DATA;
                        txd_q <= sh[0];
                        sh    <= {1'b0, sh[7:1]};
                    end
                end
                TX_DATA: begin
                    sub <= sub + 4'd1;
                    if (sub == 4'd15) begin
                        if (bitn == 4'd7) begin
                            st    <= TX_STOP;
                            txd_q <= 1'b1;
                        end else begin
                            txd_q <= sh[0];
                            sh    <= {1'b0, sh[7:1]};
                            bitn  <= bitn + 4'd1;
                        end
                    end
                end
                TX_STOP: begin
                    sub <= sub + 4'd1;
                    if (sub == 4'd15) st <= TX_IDLE;
                end
                TX_BREAK: begin
                    sub <= sub + 4'd1;
                    if (sub == 4'd15) begin
                        if (bitn == 4'd9) begin
                            st    <= TX_IDLE;
                            txd_q <= 1'b1;
                        end else begin
                            bitn <= bitn + 4'd1;
                        end
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sp_rx.sv
// Module: sp_rx
// Oversampling receiver. It synchronises the line, finds a start edge on a tick,
// rechecks the start bit 8 ticks later, samples each bit at its middle and
// emits a one-cycle valid pulse for each good frame. A bad stop bit makes it wait
// for the line to go high again. Assumes 'run' low means hold in idle.
module sp_rx
    import sp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] data
);
    logic       s1, s2;
    rx_state_e  st;
    logic [3:0] sub;
    logic [2:0] bitn;
    logic [7:0] sh;

    assign data = sh;

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    // Frame recovery state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            st    <= RX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            sh    <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (tick) begin
                case (st)
                    RX_IDLE: begin
                        sub <= '0;
                        if (!s2) st <= RX_START;
                    end
                    RX_START: begin
                        sub <= sub + 4'd1;
                        if (sub == 4'd7 && s2) begin
                            st <= RX_IDLE;
                        end else if (sub == 4'd15) begin
                            st   <= RX_DATA;
                            bitn <= '0;
                        end
                    end
                    RX_DATA: begin
                        sub <= sub + 4'd1;
                        if (sub == 4'd7) sh <= {s2, sh[7:1]};
                        if (sub == 4'd15) begin
                            if (bitn == 3'd7) st <= RX_STOP;
                            bitn <= bitn + 3'd1;
                        end
                    end
                    RX_STOP: begin
                        sub <= sub + 4'd1;
                        if (sub == 4'd7) begin
                            if (s2) begin
                                valid <= 1'b1;
                                st    <= RX_IDLE;
                            end else begin
                                st <= RX_WAITHI;
                            end
                        end
                    end
                    RX_WAITHI: begin
                        if (s2) st <= RX_IDLE;
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sp_uart.sv
// Module: sp_uart (top)
// Register front end, bit-rate prescaler and FIFOs around the serial engines.
// The bus is word-addressed on a byte address and reads are combinational.
// A read strobe on the receive data address pops one byte.
// Assumes one write or read strobe per cycle at most.
module sp_uart
    import sp_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        txd,
    input  logic        rxd
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);

    logic             mode_en;
    logic [2:0]       ctl;          // {rx enable, break, tx enable}
    logic             ovr_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] pre_cnt;
    logic             tick;

    logic wr_mode, wr_mode_clr, wr_mode_set;
    logic wr_stat, wr_stat_clr, wr_stat_set;

    logic [7:0]    tx_head, rx_head, rx_byte;
    logic          tx_empty, tx_full, tx_pop, tx_push, tx_busy, brk_done;
    logic          rx_empty, rx_full, rx_pop, rx_push, rx_valid;
    logic [LW-1:0] tx_level, rx_level;
    logic          tx_empty_flag;

    assign wr_mode     = bus_wr && (bus_addr == A_MODE);
    assign wr_mode_clr = bus_wr && (bus_addr == (A_MODE | OFS_CLR));
    assign wr_mode_set = bus_wr && (bus_addr == (A_MODE | OFS_SET));
    assign wr_stat     = bus_wr && (bus_addr == A_STAT);
    assign wr_stat_clr = bus_wr && (bus_addr == (A_STAT | OFS_CLR));
    assign wr_stat_set = bus_wr && (bus_addr == (A_STAT | OFS_SET));

    assign tx_push       = bus_wr && (bus_addr == A_TXDATA) && mode_en && !tx_full;
    assign rx_pop        = bus_rd && (bus_addr == A_RXDATA) && !rx_empty;
    assign rx_push       = rx_valid && !ovr_q && !rx_full;
    assign tick          = mode_en && (pre_cnt == '0);
    assign tx_empty_flag = tx_empty && !tx_busy;

    // Global enable bit with its set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)                                mode_en <= 1'b0;
        else if (wr_mode)                          mode_en <= bus_wdata[B_GLOBAL];
        else if (wr_mode_clr && bus_wdata[B_GLOBAL]) mode_en <= 1'b0;
        else if (wr_mode_set && bus_wdata[B_GLOBAL]) mode_en <= 1'b1;
    end

    // Control bits of the status register; the break bit clears itself when done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (wr_stat)          ctl <= bus_wdata[B_RXEN:B_TXEN];
            else if (wr_stat_clr) ctl <= ctl & ~bus_wdata[B_RXEN:B_TXEN];
            else if (wr_stat_set) ctl <= ctl | bus_wdata[B_RXEN:B_TXEN];
            if (brk_done) ctl[1] <= 1'b0;
        end
    end

    // Sticky receive overrun; only the clear alias removes it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ovr_q <= 1'b0;
        else if (rx_valid && !ovr_q && rx_full)      ovr_q <= 1'b1;
        else if (wr_stat_clr && bus_wdata[B_OVR])    ovr_q <= 1'b0;
    end

    // Divisor register.
    always_ff @(posedge clk) begin
        if (!rst_n)                               div_q <= '0;
        else if (bus_wr && bus_addr == A_DIV)     div_q <= bus_wdata[DIV_W-1:0];
    end

    // Prescaler: one tick every div_q+1 cycles while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_en) pre_cnt <= '0;
        else if (pre_cnt == '0) pre_cnt <= div_q;
        else                    pre_cnt <= pre_cnt - DIV_W'(1);
    end

    // Register read multiplexer; aliases read back their base register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE, A_MODE | OFS_CLR, A_MODE | OFS_SET:
                bus_rdata[B_GLOBAL] = mode_en;
            A_STAT, A_STAT | OFS_CLR, A_STAT | OFS_SET: begin
                bus_rdata[B_RXEN:B_TXEN] = ctl;
                bus_rdata[B_TXFULL]      = tx_full;
                bus_rdata[B_TXIDLE]      = tx_empty_flag;
                bus_rdata[B_OVR]         = ovr_q;
                bus_rdata[B_RXAV]        = !rx_empty;
            end
            A_RXDATA: bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            A_DIV:    bus_rdata[DIV_W-1:0] = div_q;
            default:  bus_rdata = '0;
        endcase
    end

    sp_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .LW(LW)) i_txq (
        .clk(clk), .rst_n(rst_n), .flush(!mode_en),
        .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_head),
        .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    sp_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .LW(LW)) i_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!mode_en),
        .push(rx_push), .din(rx_byte), .pop(rx_pop), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    sp_tx i_tx (
        .clk(clk), .rst_n(rst_n), .run(mode_en), .tick(tick),
        .tx_en(ctl[0]), .brk_req(ctl[1]),
        .fifo_empty(tx_empty), .fifo_data(tx_head), .fifo_pop(tx_pop),
        .brk_done(brk_done), .busy(tx_busy), .txd(txd)
    );

    sp_rx i_rx (
        .clk(clk), .rst_n(rst_n), .run(mode_en && ctl[2]), .tick(tick),
        .rxd(rxd), .valid(rx_valid), .data(rx_byte)
    );
endmodule

// File: rtl/sp_uart_chk.sv
// Module: sp_uart_chk
// Property checker bound into sp_uart. It watches the bus, the serial line
// and a few internal flags.
module sp_uart_chk
    import sp_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int LW         = $clog2(FIFO_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    bus_addr,
    input logic          bus_wr,
    input logic [15:0]   bus_wdata,
    input logic          txd,
    input logic          mode_en,
    input logic          ovr_q,
    input logic          tx_empty_flag,
    input logic [LW-1:0] tx_level
);
    // R2: the set alias turns on the global enable.
    p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == (A_MODE | OFS_SET) && bus_wdata[B_GLOBAL]) |=> mode_en);

    // R2: the clear alias turns off the global enable.
    p_clr_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == (A_MODE | OFS_CLR) && bus_wdata[B_GLOBAL]) |=> !mode_en);

    // R3: when disabled, the line idles high.
    p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> txd);

    // R5: an idle transmitter keeps the line high.
    p_idle_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_flag |-> txd);

    // R6: the transmit FIFO never holds more than its depth.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(FIFO_DEPTH));

    // R8: overrun stays set unless the clear alias writes bit 1.
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !(bus_wr && bus_addr == (A_STAT | OFS_CLR) && bus_wdata[B_OVR])) |=> ovr_q);
endmodule

bind sp_uart sp_uart_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LW(LW)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .txd(txd), .mode_en(mode_en), .ovr_q(ovr_q),
    .tx_empty_flag(tx_empty_flag), .tx_level(tx_level)
);

// File: tb/test_sp_uart.sv
// Directed bench for sp_uart; each scenario task checks its own results.
module test_sp_uart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        txd;
    logic        rxd = 1'b1;

    int total = 0;
    int bad   = 0;
    int bt    = 16;

    always #4 clk = ~clk;   // 125 MHz

    sp_uart i_sp_uart (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txd(txd), .rxd(rxd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_v);
        logic [9:0] fr;
        fr = {stop_v, b, 1'b0};
        @(negedge clk); rxd = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            rxd = fr[i];
            repeat (bt) @(negedge clk);
        end
        rxd = 1'b1;
    endtask

    task automatic recv_tx(output logic [7:0] b, output logic ok);
        int guard = 0;
        b = '0; ok = 1'b0;
        while (txd !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        if (guard >= 4000) return;
        repeat (bt / 2 - 1) @(negedge clk);
        ok = (txd == 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (bt) @(negedge clk);
            b[i] = txd;
        end
        repeat (bt) @(negedge clk);
        ok = ok && (txd == 1'b1);
    endtask

    task automatic low_width(output int n);
        int guard = 0;
        n = 0;
        while (txd !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (txd === 1'b0 && n < 4000) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(8'h00, d); chk("R1 mode reset", d, 16'h0000);
        rd(8'h10, d); chk("R1 status reset", d, 16'h0100);
        rd(8'h40, d); chk("R1 divisor reset", d, 16'h0000);
        chk("R1 txd idle", txd, 1'b1);
    endtask

    task automatic t_alias;
        logic [15:0] d;
        wr(8'h08, 16'h8000);
        rd(8'h00, d); chk("R2 mode set alias", d, 16'h8000);
        rd(8'h08, d); chk("R2 alias reads base", d, 16'h8000);
        wr(8'h18, 16'h1400);
        rd(8'h10, d); chk("R2 status set alias", d, 16'h1500);
        wr(8'h14, 16'h0400);
        rd(8'h10, d); chk("R2 clear only written bit", d, 16'h1100);
        wr(8'h18, 16'h0400);
    endtask

    task automatic t_tx_frame;
        logic [7:0] b; logic ok; logic [15:0] d;
        wr(8'h20, 16'h00A5);
        recv_tx(b, ok);
        chk("R5 tx byte", b, 8'hA5);
        chk("R5 tx start/stop", ok, 1'b1);
        repeat (bt) @(negedge clk);
        rd(8'h10, d); chk("R5 idle flag after frame", d[8], 1'b1);
    endtask

    task automatic t_baud;
        int n;
        wr(8'h40, 16'd2);
        bt = 48;
        wr(8'h20, 16'h0001);
        low_width(n);
        chk("R4 start bit width div=2", n, 48);
        repeat (12 * 48) @(negedge clk);
        wr(8'h40, 16'd0);
        bt = 16;
    endtask

    task automatic t_tx_fifo;
        logic [15:0] d; logic [7:0] b; logic ok; int hi;
        wr(8'h14, 16'h0400);
        for (int i = 0; i < 5; i++) wr(8'h20, 16'h0011 + 16'(i));
        rd(8'h10, d);
        chk("R6 full flag", d[9], 1'b1);
        chk("R5 not idle while queued", d[8], 1'b0);
        hi = 1;
        for (int i = 0; i < 50; i++) begin @(negedge clk); if (txd !== 1'b1) hi = 0; end
        chk("R5 no frame without tx enable", hi, 1);
        wr(8'h18, 16'h0400);
        for (int i = 0; i < 4; i++) begin
            recv_tx(b, ok);
            chk("R6 fifo order", b, 8'h11 + 8'(i));
        end
        hi = 1;
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd !== 1'b1) hi = 0; end
        chk("R6 fifth write dropped", hi, 1);
        rd(8'h10, d); chk("R5 idle after drain", d[9:8], 2'b01);
    endtask

    task automatic t_rx;
        logic [15:0] d;
        send_rx(8'h3C, 1'b1);
        rd(8'h10, d); chk("R7 data available", d[0], 1'b1);
        rd(8'h30, d); chk("R7 rx byte", d, 16'h003C);
        rd(8'h10, d); chk("R7 popped", d[0], 1'b0);
        send_rx(8'h81, 1'b1);
        send_rx(8'h7E, 1'b1);
        rd(8'h30, d); chk("R7 oldest first", d[7:0], 8'h81);
        rd(8'h30, d); chk("R7 second", d[7:0], 8'h7E);
    endtask

    task automatic t_overrun;
        logic [15:0] d;
        for (int i = 0; i < 5; i++) send_rx(8'hA0 + 8'(i), 1'b1);
        rd(8'h10, d); chk("R8 overrun set", d[1:0], 2'b11);
        for (int i = 0; i < 4; i++) begin
            rd(8'h30, d); chk("R8 kept first four", d[7:0], 8'hA0 + 8'(i));
        end
        send_rx(8'hB0, 1'b1);
        rd(8'h10, d); chk("R8 blocked while set", d[1:0], 2'b10);
        wr(8'h10, 16'h1400);
        rd(8'h10, d); chk("R2 base write keeps overrun", d[1], 1'b1);
        wr(8'h14, 16'h0002);
        send_rx(8'hB1, 1'b1);
        rd(8'h10, d); chk("R8 cleared", d[1:0], 2'b01);
        rd(8'h30, d); chk("R8 resumes", d[7:0], 8'hB1);
    endtask

    task automatic t_false_start;
        logic [15:0] d;
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        rd(8'h10, d); chk("R9 glitch rejected", d[0], 1'b0);
        send_rx(8'h5A, 1'b1);
        rd(8'h30, d); chk("R9 recovers", d[7:0], 8'h5A);
    endtask

    task automatic t_framing;
        logic [15:0] d;
        send_rx(8'h66, 1'b0);
        rxd = 1'b0;
        repeat (40) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        rd(8'h10, d); chk("R10 bad stop discarded", d[0], 1'b0);
        send_rx(8'h99, 1'b1);
        rd(8'h30, d); chk("R10 recovers", d[7:0], 8'h99);
    endtask

    task automatic t_rx_enable;
        logic [15:0] d;
        wr(8'h14, 16'h1000);
        send_rx(8'h42, 1'b1);
        rd(8'h10, d); chk("R12 not stored when disabled", d[0], 1'b0);
        wr(8'h18, 16'h1000);
    endtask

    task automatic t_break;
        logic [7:0] b; logic ok; int n; logic [15:0] d;
        wr(8'h20, 16'h0055);
        wr(8'h18, 16'h0800);
        recv_tx(b, ok);
        chk("R11 frame finishes first", b, 8'h55);
        chk("R11 frame intact", ok, 1'b1);
        low_width(n);
        chk("R11 break width", n, 160);
        rd(8'h10, d); chk("R11 break bit self-clears", d[11], 1'b0);
    endtask

    task automatic t_disable;
        logic [15:0] d; int hi;
        send_rx(8'h24, 1'b1);
        wr(8'h14, 16'h0400);
        wr(8'h20, 16'h0001);
        wr(8'h20, 16'h0002);
        wr(8'h00, 16'h0000);
        rd(8'h10, d); chk("R3 fifos flushed", {d[9:8], d[0]}, 3'b010);
        chk("R3 line high", txd, 1'b1);
        wr(8'h08, 16'h8000);
        wr(8'h18, 16'h0400);
        hi = 1;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (txd !== 1'b1) hi = 0; end
        chk("R3 nothing left to send", hi, 1);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_alias;
        t_tx_frame;
        t_baud;
        t_tx_fifo;
        t_rx;
        t_overrun;
        t_false_start;
        t_framing;
        t_rx_enable;
        t_break;
        t_disable;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule